// File: doc/BRIEF.md
# Reduced Legacy DMA Channel Controller

This block holds the channel state of a cascaded pair of legacy-style DMA controllers and decides which channel is served next. The slave controller owns channels 0 to 3. The master controller owns channels 4 to 7. Channel 4 is the fixed link that carries the slave's request into the master, so it never moves data itself. Software programs the block through a byte-wide register port. Each channel has a 16-bit start address and a 16-bit transfer count, plus a stored mode. Each controller has a disable bit, a four-bit mask and a status byte.

When an unmasked channel requests service, the block raises `xfer_valid`. It also presents the winning channel, the transfer type, the data width and the current address. An external bus engine performs the move and pulses `xfer_ack`. On that pulse the block advances the address, decrements the count and handles terminal count. In single mode the channel is released after every transfer. In demand mode the channel is held while its request stays high.

Top module: `dma_pair_ctl`

## Requirements
- R1: After reset, both mask nibbles read 0xF, both status TC nibbles read 0, both command reads return 0, and `xfer_valid` is low.
- R2: The channel register byte address is {0, channel[2:0], sel, hi}, where sel=0 is the address and sel=1 is the count, and hi=1 is bits 15:8. A write sets both the base copy and the current copy of that byte. A read returns the current copy.
- R3: When several enabled channels request, the lowest-numbered one is granted. The order is 0,1,2,3,5,6,7, because the slave group enters the master at channel 4.
- R4: Each acknowledged transfer increments the current address by 1 and decrements the current count by 1. While granted, `xfer_chan` is the channel and `xfer_kind` is mode bits 3:2 (0 verify, 1 write, 2 read). `xfer_wide` is 1 exactly for channels 5 to 7. These outputs hold until `xfer_ack`.
- R5: A transfer acknowledged while the current count is 0 is the last one, and `xfer_last` is high during it. It sets the channel's status TC bit. With auto-initialization off, it also sets the channel's mask bit and leaves the count at 0xFFFF. Programming count N therefore yields N+1 transfers.
- R6: With mode bit 4 set, terminal count reloads the current address and count from the base copies and leaves the mask bit clear.
- R7: In single mode (mode bits 7:6 = 01), `xfer_valid` is low in the cycle after each acknowledged transfer.
- R8: In demand mode (mode bits 7:6 = 00), the channel keeps `xfer_valid` high in consecutive cycles while its request stays high, up to terminal count.
- R9: A channel with mode bits 7:6 = 10 or 11, or with type bits 3:2 = 11, is never granted.
- R10: Channel 4 is never granted, and `chan_req[4]` has no effect. Its address and count registers can still be written and read back.
- R11: Controller register byte address is {1, ctrl, 0, 0, off}, where ctrl=0 is the slave and ctrl=1 is the master. Off values are 0 command, 1 mode, 2 mask and 3 status. Command bit 2 set to 1 disables that controller, and disabling the master also stops the slave group. Master mask bit 0 (channel 4) blocks the whole slave group. All other command bits have no effect.
- R12: Mode bit 5 is ignored, and the address always increments.
- R13: The status byte reads {request nibble, TC nibble}. Writing the status address clears the TC bits that are written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| chan_req | input | 8 | Per-channel service requests |
| xfer_ack | input | 1 | One transfer completed by the bus engine |
| xfer_valid | output | 1 | A channel is granted and a transfer is wanted |
| xfer_chan | output | 3 | Granted channel |
| xfer_kind | output | 2 | Transfer type: 0 verify, 1 write, 2 read |
| xfer_wide | output | 1 | 16-bit transfer |
| xfer_addr | output | 16 | Current address of the granted channel |
| xfer_last | output | 1 | This transfer reaches terminal count |

## Verification
The bench sweeps every usable channel through both legal modes and all three transfer types, with mode bit 5 toggled. It counts the exact number of transfers against the programmed count. A count that stops one early, or an address that repeats the first value, shows up directly in this sweep. It walks all 255 request patterns to pin down fixed priority. A design that lets channel 4 win, or that ranks the slave group after channels 5 to 7, fails there. The bench also checks the remaining corner cases:
- The unsupported mode and type codes.
- Disable and mask gating through the cascade link.
- Auto-reload at terminal count, where a design that masks instead of reloading stops the channel.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        XM_DEMAND = 2'b00,
        XM_SINGLE = 2'b01,
        XM_BLK_NA = 2'b10,
        XM_CAS_NA = 2'b11
    } xmode_e;

    typedef enum logic [1:0] {
        XT_VERIFY = 2'b00,
        XT_WRITE  = 2'b01,
        XT_READ   = 2'b10,
        XT_BAD    = 2'b11
    } xtype_e;

    localparam logic [1:0] CR_CMD  = 2'd0;
    localparam logic [1:0] CR_MODE = 2'd1;
    localparam logic [1:0] CR_MASK = 2'd2;
    localparam logic [1:0] CR_STAT = 2'd3;
    localparam int         DIS_BIT = 2;
endpackage

// File: rtl/dma_elig.sv
module dma_elig
    import dma_pkg::*;
#(
    parameter  int NCH  = 8,
    parameter  int GRP  = 4,
    localparam int NGRP = NCH / GRP
) (
    input  logic [NCH-1:0]      req,
    input  logic [NCH-1:0]      mask,
    input  logic [NGRP-1:0]     dis,
    input  logic [NCH-1:0][1:0] xmode,
    input  logic [NCH-1:0][1:0] xtype,
    output logic [NCH-1:0]      elig
);
    logic [NCH-1:0] base_ok;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign base_ok[c] = req[c] & ~mask[c]
                          & (xmode[c] == XM_DEMAND || xmode[c] == XM_SINGLE)
                          & (xtype[c] != XT_BAD);
        if (c == GRP) begin : g_link
            // cascade link: never serves a transfer of its own
            assign elig[c] = base_ok[c] & 1'b0;
        end else if (c < GRP) begin : g_slave
            assign elig[c] = base_ok[c] & ~dis[0] & ~dis[NGRP-1] & ~mask[GRP];
        end else begin : g_master
            assign elig[c] = base_ok[c] & ~dis[NGRP-1];
        end
    end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter  int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
    import dma_pkg::*;
#(
    parameter  int NCH  = 8,
    parameter  int GRP  = 4,
    parameter  int AW   = 16,
    parameter  int CW   = 16,
    localparam int CH_W = $clog2(NCH),
    localparam int AD   = CH_W + 3,
    localparam int NGRP = NCH / GRP
) (
    input  logic [AD-1:0]         addr,
    input  logic [NCH-1:0][AW-1:0] cur_addr,
    input  logic [NCH-1:0][CW-1:0] cur_cnt,
    input  logic [NCH-1:0]        mask,
    input  logic [NCH-1:0]        tc,
    input  logic [NGRP-1:0]       dis,
    input  logic [NCH-1:0]        req,
    output logic [7:0]            rdata
);
    always_comb begin
        logic [CH_W-1:0] ch;
        logic [15:0]     word;
        int              gi;
        ch    = addr[AD-2 -: CH_W];
        gi    = int'(addr[AD-2]);
        word  = addr[1] ? 16'(cur_cnt[ch]) : 16'(cur_addr[ch]);
        rdata = '0;
        if (!addr[AD-1]) begin
            rdata = addr[0] ? word[15:8] : word[7:0];
        end else begin
            case (addr[1:0])
                CR_CMD:  rdata[DIS_BIT] = dis[gi];
                CR_MASK: rdata = 8'(mask[gi*GRP +: GRP]);
                CR_STAT: rdata = 8'({req[gi*GRP +: GRP], tc[gi*GRP +: GRP]});
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_pair_ctl.sv
module dma_pair_ctl
    import dma_pkg::*;
#(
    parameter  int NCH  = 8,
    parameter  int GRP  = 4,
    parameter  int AW   = 16,
    parameter  int CW   = 16,
    localparam int CH_W = $clog2(NCH),
    localparam int GW   = $clog2(GRP),
    localparam int AD   = CH_W + 3,
    localparam int NGRP = NCH / GRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [AD-1:0]   reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic [NCH-1:0]  chan_req,
    input  logic            xfer_ack,
    output logic            xfer_valid,
    output logic [CH_W-1:0] xfer_chan,
    output logic [1:0]      xfer_kind,
    output logic            xfer_wide,
    output logic [AW-1:0]   xfer_addr,
    output logic            xfer_last
);
    typedef struct packed {
        logic [NCH-1:0][AW-1:0] base_addr;
        logic [NCH-1:0][AW-1:0] cur_addr;
        logic [NCH-1:0][CW-1:0] base_cnt;
        logic [NCH-1:0][CW-1:0] cur_cnt;
        logic [NCH-1:0][1:0]    xmode;
        logic [NCH-1:0][1:0]    xtype;
        logic [NCH-1:0]         autoi;
        logic [NCH-1:0]         mask;
        logic [NCH-1:0]         tc;
        logic [NGRP-1:0]        dis;
        logic                   busy;
        logic [CH_W-1:0]        act;
    } st_t;

    st_t s_d, s_q;

    logic [NCH-1:0]  elig;
    logic            win_any;
    logic [CH_W-1:0] win_idx;
    logic            cnt_zero;
    logic            act_single;

    dma_elig #(.NCH(NCH), .GRP(GRP)) u_elig (
        .req   (chan_req),
        .mask  (s_q.mask),
        .dis   (s_q.dis),
        .xmode (s_q.xmode),
        .xtype (s_q.xtype),
        .elig  (elig)
    );

    dma_prio_pick #(.N(NCH)) u_pick (
        .req (elig),
        .any (win_any),
        .idx (win_idx)
    );

    dma_rd_mux #(.NCH(NCH), .GRP(GRP), .AW(AW), .CW(CW)) u_rd (
        .addr     (reg_addr),
        .cur_addr (s_q.cur_addr),
        .cur_cnt  (s_q.cur_cnt),
        .mask     (s_q.mask),
        .tc       (s_q.tc),
        .dis      (s_q.dis),
        .req      (chan_req),
        .rdata    (reg_rdata)
    );

    assign cnt_zero   = (s_q.cur_cnt[s_q.act] == '0);
    assign act_single = (s_q.xmode[s_q.act] == XM_SINGLE);

    always_comb begin
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] ch;
        logic [CH_W-1:0] mc;
        int              gi;
        int              bo;
        s_d = s_q;
        a   = s_q.act;
        ch  = reg_addr[AD-2 -: CH_W];
        gi  = int'(reg_addr[AD-2]);
        bo  = int'(reg_addr[0]) * 8;
        mc  = CH_W'(gi * GRP + int'(reg_wdata[GW-1:0]));

        // transfer bookkeeping and arbitration
        if (s_q.busy) begin
            if (xfer_ack) begin
                s_d.cur_addr[a] = s_q.cur_addr[a] + 1'b1;
                s_d.cur_cnt[a]  = s_q.cur_cnt[a] - 1'b1;
                if (cnt_zero) begin
                    s_d.tc[a] = 1'b1;
                    if (s_q.autoi[a]) begin
                        s_d.cur_addr[a] = s_q.base_addr[a];
                        s_d.cur_cnt[a]  = s_q.base_cnt[a];
                    end else begin
                        s_d.mask[a] = 1'b1;
                    end
                end
                s_d.busy = (s_q.xmode[a] == XM_DEMAND) & ~cnt_zero & elig[a];
            end
        end else if (win_any) begin
            s_d.busy = 1'b1;
            s_d.act  = win_idx;
        end

        // register port, applied after the transfer update
        if (reg_we) begin
            if (!reg_addr[AD-1]) begin
                if (!reg_addr[1]) begin
                    s_d.base_addr[ch][bo +: 8] = reg_wdata;
                    s_d.cur_addr[ch][bo +: 8]  = reg_wdata;
                end else begin
                    s_d.base_cnt[ch][bo +: 8]  = reg_wdata;
                    s_d.cur_cnt[ch][bo +: 8]   = reg_wdata;
                end
            end else begin
                case (reg_addr[1:0])
                    CR_CMD:  s_d.dis[gi] = reg_wdata[DIS_BIT];
                    CR_MODE: begin
                        s_d.xmode[mc] = reg_wdata[7:6];
                        s_d.autoi[mc] = reg_wdata[4];
                        s_d.xtype[mc] = reg_wdata[3:2];
                    end
                    CR_MASK: s_d.mask[gi*GRP +: GRP] = reg_wdata[GRP-1:0];
                    default: s_d.tc[gi*GRP +: GRP] = s_q.tc[gi*GRP +: GRP] & ~reg_wdata[GRP-1:0];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign xfer_valid = s_q.busy;
    assign xfer_chan  = s_q.act;
    assign xfer_kind  = s_q.xtype[s_q.act];
    assign xfer_wide  = s_q.act >= CH_W'(GRP + 1);
    assign xfer_addr  = s_q.cur_addr[s_q.act];
    assign xfer_last  = s_q.busy & cnt_zero;
endmodule

// File: rtl/dma_pair_chk.sv
module dma_pair_chk #(
    parameter int CH_W = 3,
    parameter int AW   = 16,
    parameter int CASC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_we,
    input logic            xfer_valid,
    input logic            xfer_ack,
    input logic [CH_W-1:0] xfer_chan,
    input logic [1:0]      xfer_kind,
    input logic [AW-1:0]   xfer_addr,
    input logic            xfer_last,
    input logic            act_single
);
    assert_no_link_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> xfer_chan != CH_W'(CASC));

    assert_legal_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> xfer_kind != 2'b11);

    assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ack) |=> (xfer_valid && xfer_chan == $past(xfer_chan)));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_ack && !xfer_last && !reg_we) |=>
        (!xfer_valid || xfer_chan != $past(xfer_chan) || xfer_addr == $past(xfer_addr) + 1'b1));

    assert_single_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_ack && act_single) |=> !xfer_valid);

    assert_tc_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_ack && xfer_last) |=> !xfer_valid);
endmodule

bind dma_pair_ctl dma_pair_chk #(.CH_W(CH_W), .AW(AW), .CASC(GRP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .xfer_valid (xfer_valid),
    .xfer_ack   (xfer_ack),
    .xfer_chan  (xfer_chan),
    .xfer_kind  (xfer_kind),
    .xfer_addr  (xfer_addr),
    .xfer_last  (xfer_last),
    .act_single (act_single)
);

// File: tb/sim_dma_pair_ctl.sv
`timescale 1ns/1ps
module sim_dma_pair_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [7:0]  chan_req = '0;
    logic        xfer_ack = 1'b0;
    logic        xfer_valid;
    logic [2:0]  xfer_chan;
    logic [1:0]  xfer_kind;
    logic        xfer_wide;
    logic [15:0] xfer_addr;
    logic        xfer_last;

    int checks = 0;
    int errs   = 0;

    dma_pair_ctl u0 (.*);

    always #2.5 clk = ~clk;

    function automatic logic [5:0] ca(int c, int sel, int hi);
        return 6'(c * 4 + sel * 2 + hi);
    endfunction

    function automatic logic [5:0] ctl(int g, int off);
        return 6'(32 + g * 16 + off);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set16(input int c, input int sel, input int v);
        wr(ca(c, sel, 0), 8'(v));
        wr(ca(c, sel, 1), 8'(v >> 8));
    endtask

    task automatic rd16(input int c, input int sel, output int v);
        logic [7:0] lo, hi;
        rd(ca(c, sel, 0), lo);
        rd(ca(c, sel, 1), hi);
        v = {16'd0, hi, lo};
    endtask

    task automatic setmode(input int c, input int m, input int t, input int au, input int b5);
        wr(ctl(c / 4, 1), 8'((m << 6) | (b5 << 5) | (au << 4) | (t << 2) | (c % 4)));
    endtask

    task automatic only_unmask(input int c);
        wr(ctl(0, 2), (c < 4) ? 8'(~(1 << c) & 15) : 8'hF);
        wr(ctl(1, 2), (c < 4) ? 8'hE : 8'(~(1 << (c - 4)) & 15));
    endtask

    task automatic release_all();
        @(negedge clk);
        chan_req = '0; xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_grant(input int exp, input string tag);
        @(negedge clk);
        @(negedge clk);
        if (exp < 0) chk(!xfer_valid, tag, int'(xfer_valid), 0);
        else chk(xfer_valid && xfer_chan == 3'(exp), tag, {xfer_valid, xfer_chan}, 8 + exp);
    endtask

    // drive one channel until terminal count and check every transfer
    task automatic run_chan(input int c, input int cnt, input int m, input int t, input int b5);
        int a0, k, v;
        bit prev;
        logic [7:0] d;
        a0 = 16'h1000 + c * 16'h0111 + t * 16'h20;
        set16(c, 0, a0);
        set16(c, 1, cnt);
        setmode(c, m, t, 0, b5);
        wr(ctl(c / 4, 3), 8'hF);
        only_unmask(c);
        @(negedge clk);
        chan_req[c] = 1'b1; xfer_ack = 1'b1;
        k = 0; prev = 1'b0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            @(negedge clk);
            if (xfer_valid) begin
                chk(xfer_chan == 3'(c), "R4 chan", xfer_chan, c);
                chk(xfer_addr == 16'(a0 + k), b5 ? "R12 addr inc" : "R4 addr", xfer_addr, a0 + k);
                chk(xfer_kind == 2'(t), "R4 kind", xfer_kind, t);
                chk(xfer_wide == (c >= 5), "R4 wide", xfer_wide, c >= 5);
                chk(xfer_last == (k == cnt), "R5 last flag", xfer_last, k == cnt);
                if (m == 1) chk(!prev, "R7 single gap", prev, 0);
                if (m == 0 && k > 0) chk(prev, "R8 demand burst", prev, 1);
                k++;
                prev = 1'b1;
            end else begin
                prev = 1'b0;
            end
        end
        chan_req = '0; xfer_ack = 1'b0;
        chk(k == cnt + 1, "R5 transfer total", k, cnt + 1);
        rd(ctl(c / 4, 2), d);
        chk(d[c % 4], "R5 mask set", d, 1 << (c % 4));
        rd(ctl(c / 4, 3), d);
        chk(d[c % 4], "R5 status tc", d, 1 << (c % 4));
        rd16(c, 1, v);
        chk(v == 16'hFFFF, "R5 count wrap", v, 16'hFFFF);
        rd16(c, 0, v);
        chk(v == a0 + cnt + 1, "R4 final addr", v, a0 + cnt + 1);
        wr(ctl(c / 4, 3), 8'(1 << (c % 4)));
        rd(ctl(c / 4, 3), d);
        chk(d[3:0] == 4'h0, "R13 tc clear", d, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errs++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int v, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!xfer_valid, "R1 valid low", xfer_valid, 0);
        for (int g = 0; g < 2; g++) begin
            rd(ctl(g, 2), d); chk(d == 8'h0F, "R1 mask", d, 8'h0F);
            rd(ctl(g, 3), d); chk(d[3:0] == 4'h0, "R1 status", d, 0);
            rd(ctl(g, 0), d); chk(d == 8'h00, "R1 command", d, 0);
        end

        // R2 / R10 register access on every channel including the link
        for (int c = 0; c < 8; c++) begin
            set16(c, 0, 16'hA500 + c * 16'h0103);
            set16(c, 1, 16'h5A00 + c * 16'h0207);
        end
        for (int c = 0; c < 8; c++) begin
            rd16(c, 0, v);
            chk(v == 16'hA500 + c * 16'h0103, (c == 4) ? "R10 link addr rw" : "R2 addr rw", v, 16'hA500 + c * 16'h0103);
            rd16(c, 1, v);
            chk(v == 16'h5A00 + c * 16'h0207, (c == 4) ? "R10 link count rw" : "R2 count rw", v, 16'h5A00 + c * 16'h0207);
        end

        // main sweep: every usable channel, both modes, all legal types
        for (int c = 0; c < 8; c++) begin
            if (c == 4) continue;
            for (int m = 0; m < 2; m++)
                for (int t = 0; t < 3; t++)
                    run_chan(c, (c + t + m) % 4 + 1, m, t, t % 2);
        end

        // R6 auto-initialization on a 16-bit channel
        set16(6, 0, 16'h4000);
        set16(6, 1, 1);
        setmode(6, 0, 2, 1, 0);
        wr(ctl(1, 3), 8'hF);
        only_unmask(6);
        @(negedge clk);
        chan_req[6] = 1'b1; xfer_ack = 1'b1;
        v = 0;
        for (int cyc = 0; cyc < 10; cyc++) begin
            @(negedge clk);
            if (xfer_valid) begin
                v++;
                if (xfer_last) begin chan_req = '0; break; end
            end
        end
        @(negedge clk);
        xfer_ack = 1'b0;
        @(negedge clk);
        chk(v == 2, "R6 transfers", v, 2);
        rd(ctl(1, 2), d); chk(!d[2], "R6 mask stays clear", d, 0);
        rd(ctl(1, 3), d); chk(d[2], "R6 status tc", d, 4);
        rd16(6, 0, v); chk(v == 16'h4000, "R6 addr reload", v, 16'h4000);
        rd16(6, 1, v); chk(v == 1, "R6 count reload", v, 1);

        // R3 priority over every request pattern
        for (int c = 0; c < 8; c++) begin
            set16(c, 1, 16'h8000);
            setmode(c, 1, 2, 0, 0);
        end
        wr(ctl(0, 2), 8'h0);
        wr(ctl(1, 2), 8'h0);
        for (int p = 1; p < 256; p++) begin
            @(negedge clk);
            chan_req = 8'(p);
            exp = -1;
            for (int b = 7; b >= 0; b--) if (b != 4 && p[b]) exp = b;
            expect_grant(exp, (p == 16) ? "R10 link request ignored" : "R3 priority");
            release_all();
        end

        // R9 unsupported mode and type codes on channel 0
        for (int k = 0; k < 3; k++) begin
            if (k < 2) setmode(0, 2 + k, 2, 0, 0);
            else setmode(0, 1, 3, 0, 0);
            @(negedge clk);
            chan_req = 8'h01;
            expect_grant(-1, "R9 illegal code");
            @(negedge clk);
            expect_grant(-1, "R9 illegal code later");
            chan_req = '0;
        end
        setmode(0, 1, 2, 0, 0);

        // R11 command and cascade gating
        wr(ctl(0, 0), 8'h04);
        @(negedge clk); chan_req = 8'h21;
        expect_grant(5, "R11 slave disabled");
        release_all();
        wr(ctl(0, 0), 8'hFB);
        @(negedge clk); chan_req = 8'h21;
        expect_grant(0, "R11 other command bits ignored");
        release_all();
        wr(ctl(1, 0), 8'h04);
        @(negedge clk); chan_req = 8'h21;
        expect_grant(-1, "R11 master disable stops all");
        chan_req = '0;
        wr(ctl(1, 0), 8'hFB);
        rd(ctl(1, 0), d); chk(d == 8'h00, "R11 command readback", d, 0);
        wr(ctl(1, 2), 8'h01);
        @(negedge clk); chan_req = 8'h01;
        expect_grant(-1, "R11 link mask blocks slave");
        @(negedge clk); chan_req = 8'h21;
        expect_grant(5, "R11 master still serves");
        release_all();

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule